// File: doc/BRIEF.md
# Port Activity LED Controller

This block turns the per-port status flags of a four-port repeater into the states of its indicator lamps. Each port has two lamps, one for link and activity and one for errors. A single collision lamp and a five-step network-utilization bar graph complete the set. Every lamp output is active low.

For each port the controller picks one of four lamp modes: off, steadily lit, blinking in phase A, or blinking in phase B. It bases the choice on whether a signal is present, whether the link is up, whether packets are arriving, whether the port has been excluded (partitioned, isolated or jabber-disabled) and whether a bad-carrier event is showing. A free-running blink divider sets the blink rate. Every lamp then passes through a hold stage, so that no lit or unlit period is shorter than the minimum visible time of `HOLD_CYC` clocks (40 ms of the reference clock by default).

Utilization is the count of "medium busy" clocks in a fixed window of 2^`WIN_LOG2` clocks. At the end of each window this count is compared, using shifts and adds, against five unequal thresholds. The collision lamp is fed by a one-clock collision flag and is stretched so that it can be seen.

Top module: `port_led_ctrl`

## Requirements
- R1: After a synchronous reset every lamp output is high, which means unlit. All lamp outputs are active low, so 0 means lit.
- R2: A port whose `sig_det` bit is 0 requests both of its lamps unlit, whatever its other flags are.
- R3: A port with a signal but without link requests its activity lamp unlit and its error lamp in blink phase A.
- R4: A port with link that is neither excluded nor showing a bad carrier requests its activity lamp lit and its error lamp unlit when `rx_pkt` is 0. When `rx_pkt` is 1 it requests its activity lamp in blink phase B and its error lamp unlit.
- R5: A port with link whose `port_excl` bit is 1 requests both lamps steadily lit. This takes precedence over a bad carrier and over packet reception.
- R6: A port with link whose `bad_car` bit is 1, and which is not excluded, requests its activity lamp in blink phase B and its error lamp in blink phase A.
- R7: The blink flag is 0 after reset and toggles after every `HOLD_CYC` clocks. Phase A asks for the lamp lit while the flag is 1. Phase B asks for it lit while the flag is 0.
- R8: Each lamp is a registered copy of its request. It follows a differing request on the next clock edge only when the lamp has kept its level for at least `HOLD_CYC` clocks. Otherwise it keeps its level, so every lit or unlit period lasts at least `HOLD_CYC` clocks.
- R9: A clock with `col_evt` high makes the collision request high for the next `HOLD_CYC` clocks, and a later collision restarts that period. The collision lamp follows this request under the hold rule of R8.
- R10: Utilization windows last 2^`WIN_LOG2` clocks, and the first window begins with the first clock edge after reset is released. At the last edge of a window the busy count B (the edges in that window with `medium_busy` high) sets five level bits, each 1 when its test holds. The tests are: bit 0 for B > 1%, bit 1 for B > 12.5%, bit 2 for B > 25%, bit 3 for B > 50% and bit 4 for B > 60% of the window length. Level bit k requests `util_led_n[k]` lit.
- R11: The level bits are 0 after reset and change only at window ends. The utilization lamps follow them under the hold rule of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| sig_det | input | NPORT | Per-port: receive signal present |
| link_up | input | NPORT | Per-port: link established and descrambler locked |
| rx_pkt | input | NPORT | Per-port: packet being received |
| port_excl | input | NPORT | Per-port: port partitioned, isolated or jabber-disabled |
| bad_car | input | NPORT | Per-port: false carrier or invalid data being shown |
| col_evt | input | 1 | One-clock collision flag |
| medium_busy | input | 1 | Per-clock flag that the medium carries traffic |
| act_led_n | output | NPORT | Per-port link/activity lamp, active low |
| err_led_n | output | NPORT | Per-port error lamp, active low |
| col_led_n | output | 1 | Collision lamp, active low |
| util_led_n | output | 5 | Utilization bar graph, bit 0 lowest threshold, active low |

## Verification
A wrong hold counter shows up as a lamp that changes level sooner or later than allowed. The reference model sees this on the first transition that follows, which is at most `HOLD_CYC` clocks after the fault. A wrong blink phase or a wrong mode decode makes an activity or error lamp differ from the model within one blink half-period of the port entering that state. A wrong busy count or wrong threshold arithmetic stays hidden until the end of the current window, after which one utilization lamp differs. The bench therefore aligns its busy bursts to window boundaries and places counts just on either side of each threshold.

// File: rtl/port_ind_pkg.sv
package port_ind_pkg;

  typedef enum logic [1:0] {
    LAMP_OFF  = 2'd0,
    LAMP_ON   = 2'd1,
    LAMP_PH_A = 2'd2,
    LAMP_PH_B = 2'd3
  } lamp_mode_e;

  localparam int NUM_UTIL = 5;

  function automatic logic lamp_lit(input lamp_mode_e mode, input logic blink);
    case (mode)
      LAMP_ON:   lamp_lit = 1'b1;
      LAMP_PH_A: lamp_lit = blink;
      LAMP_PH_B: lamp_lit = ~blink;
      default:   lamp_lit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/port_lamp_decode.sv
module port_lamp_decode #(
  parameter int NPORT = 4
) (
  input  logic [NPORT-1:0] sig_det,
  input  logic [NPORT-1:0] link_up,
  input  logic [NPORT-1:0] rx_pkt,
  input  logic [NPORT-1:0] port_excl,
  input  logic [NPORT-1:0] bad_car,
  input  logic             blink,
  output logic [NPORT-1:0] act_req,
  output logic [NPORT-1:0] err_req
);
  import port_ind_pkg::*;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    lamp_mode_e act_mode;
    lamp_mode_e err_mode;

    always_comb begin
      act_mode = LAMP_OFF;
      err_mode = LAMP_OFF;
      if (sig_det[p]) begin
        if (!link_up[p]) begin
          err_mode = LAMP_PH_A;
        end else if (port_excl[p]) begin
          act_mode = LAMP_ON;
          err_mode = LAMP_ON;
        end else if (bad_car[p]) begin
          act_mode = LAMP_PH_B;
          err_mode = LAMP_PH_A;
        end else if (rx_pkt[p]) begin
          act_mode = LAMP_PH_B;
        end else begin
          act_mode = LAMP_ON;
        end
      end
    end

    assign act_req[p] = lamp_lit(act_mode, blink);
    assign err_req[p] = lamp_lit(err_mode, blink);
  end

endmodule

// File: rtl/ind_hold.sv
module ind_hold #(
  parameter int HOLD_CYC = 1000000
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic lit
);
  localparam int AW = $clog2(HOLD_CYC + 1);
  localparam logic [AW-1:0] FULL = AW'(HOLD_CYC);

  logic [AW-1:0] age_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lit   <= 1'b0;
      age_q <= FULL;
    end else if ((req != lit) && (age_q == FULL)) begin
      lit   <= req;
      age_q <= AW'(1);
    end else if (age_q != FULL) begin
      age_q <= age_q + AW'(1);
    end
  end

  // R8
  hold_min_chk: assert property (@(posedge clk) disable iff (rst)
    (age_q != FULL) |=> $stable(lit));

  // R8
  hold_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ((age_q == FULL) && (req != lit)) |=> (lit == $past(req)));

endmodule

// File: rtl/util_meter.sv
module util_meter #(
  parameter int WIN_LOG2 = 22
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       busy,
  output logic [4:0] level
);
  localparam int CW = WIN_LOG2 + 1;
  localparam int XW = WIN_LOG2 + 8;
  localparam logic [XW-1:0] WIN = XW'(1) << WIN_LOG2;

  logic [WIN_LOG2-1:0] win_q;
  logic [CW-1:0]       busy_q;
  logic [CW-1:0]       total;
  logic [XW-1:0]       t;
  logic [4:0]          lvl_next;
  logic                win_end;

  assign win_end = &win_q;
  assign total   = busy_q + CW'(busy);
  assign t       = XW'(total);

  always_comb begin
    lvl_next[0] = ((t << 6) + (t << 5) + (t << 2)) > WIN;   // x100 > window
    lvl_next[1] = t > (WIN >> 3);
    lvl_next[2] = t > (WIN >> 2);
    lvl_next[3] = t > (WIN >> 1);
    lvl_next[4] = ((t << 2) + t) > ((WIN << 1) + WIN);      // x5 > 3 windows
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q  <= '0;
      busy_q <= '0;
      level  <= '0;
    end else begin
      win_q <= win_q + WIN_LOG2'(1);
      if (win_end) begin
        busy_q <= '0;
        level  <= lvl_next;
      end else begin
        busy_q <= total;
      end
    end
  end

  // R10
  util_thermo_chk: assert property (@(posedge clk) disable iff (rst)
    (((level >> 1) & ~level) == 5'd0));

  // R11
  util_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !win_end |=> $stable(level));

endmodule

// File: rtl/port_led_ctrl.sv
module port_led_ctrl #(
  parameter int NPORT    = 4,
  parameter int HOLD_CYC = 1000000,
  parameter int WIN_LOG2 = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPORT-1:0] sig_det,
  input  logic [NPORT-1:0] link_up,
  input  logic [NPORT-1:0] rx_pkt,
  input  logic [NPORT-1:0] port_excl,
  input  logic [NPORT-1:0] bad_car,
  input  logic             col_evt,
  input  logic             medium_busy,
  output logic [NPORT-1:0] act_led_n,
  output logic [NPORT-1:0] err_led_n,
  output logic             col_led_n,
  output logic [4:0]       util_led_n
);
  import port_ind_pkg::*;

  localparam int BW = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;
  localparam int CW = $clog2(HOLD_CYC + 1);

  logic [BW-1:0]       bcnt_q;
  logic                blink_q;
  logic [CW-1:0]       col_q;
  logic [NPORT-1:0]    act_req, err_req, act_lit, err_lit;
  logic [NUM_UTIL-1:0] util_lvl, util_lit;
  logic                col_lit;

  always_ff @(posedge clk) begin
    if (rst) begin
      bcnt_q  <= '0;
      blink_q <= 1'b0;
    end else if (bcnt_q == BW'(HOLD_CYC - 1)) begin
      bcnt_q  <= '0;
      blink_q <= ~blink_q;
    end else begin
      bcnt_q  <= bcnt_q + BW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               col_q <= '0;
    else if (col_evt)      col_q <= CW'(HOLD_CYC);
    else if (col_q != '0)  col_q <= col_q - CW'(1);
  end

  port_lamp_decode #(.NPORT(NPORT)) u_dec (
    .sig_det(sig_det), .link_up(link_up), .rx_pkt(rx_pkt),
    .port_excl(port_excl), .bad_car(bad_car), .blink(blink_q),
    .act_req(act_req), .err_req(err_req)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_lamp
    ind_hold #(.HOLD_CYC(HOLD_CYC)) u_act (
      .clk(clk), .rst(rst), .req(act_req[p]), .lit(act_lit[p]));
    ind_hold #(.HOLD_CYC(HOLD_CYC)) u_err (
      .clk(clk), .rst(rst), .req(err_req[p]), .lit(err_lit[p]));
  end

  ind_hold #(.HOLD_CYC(HOLD_CYC)) u_col (
    .clk(clk), .rst(rst), .req(col_q != '0), .lit(col_lit));

  util_meter #(.WIN_LOG2(WIN_LOG2)) u_util (
    .clk(clk), .rst(rst), .busy(medium_busy), .level(util_lvl));

  for (genvar k = 0; k < NUM_UTIL; k++) begin : g_util
    ind_hold #(.HOLD_CYC(HOLD_CYC)) u_bar (
      .clk(clk), .rst(rst), .req(util_lvl[k]), .lit(util_lit[k]));
  end

  assign act_led_n  = ~act_lit;
  assign err_led_n  = ~err_lit;
  assign col_led_n  = ~col_lit;
  assign util_led_n = ~util_lit;

  // R7
  blink_period_chk: assert property (@(posedge clk) disable iff (rst)
    (bcnt_q != BW'(HOLD_CYC - 1)) |=> $stable(blink_q));

  // R9
  col_load_chk: assert property (@(posedge clk) disable iff (rst)
    col_evt |=> (col_q == CW'(HOLD_CYC)));

  // R9
  col_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (!col_evt && (col_q != '0)) |=> (col_q == $past(col_q) - CW'(1)));

endmodule

// File: tb/tb_port_led_ctrl.sv
module tb_port_led_ctrl;
  localparam int NP   = 4;
  localparam int HOLD = 8;
  localparam int WL   = 8;
  localparam int WLEN = 1 << WL;
  localparam int NL   = 2 * NP + 1 + 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0] sig_det = '0, link_up = '0, rx_pkt = '0, port_excl = '0, bad_car = '0;
  logic col_evt = 1'b0, medium_busy = 1'b0;
  logic [NP-1:0] act_led_n, err_led_n;
  logic col_led_n;
  logic [4:0] util_led_n;

  always #5 clk = ~clk;

  port_led_ctrl #(.NPORT(NP), .HOLD_CYC(HOLD), .WIN_LOG2(WL)) dut (
    .clk(clk), .rst(rst), .sig_det(sig_det), .link_up(link_up), .rx_pkt(rx_pkt),
    .port_excl(port_excl), .bad_car(bad_car), .col_evt(col_evt),
    .medium_busy(medium_busy), .act_led_n(act_led_n), .err_led_n(err_led_n),
    .col_led_n(col_led_n), .util_led_n(util_led_n));

  int checks = 0, errors = 0, cyc = 0, since_rst = 0;
  bit started = 0;

  // reference model state: lamps 0..3 activity, 4..7 error, 8 collision, 9..13 utilization
  int  lit_m[NL], age_m[NL];
  int  blink_m, bcnt_m, colc_m, win_m, busy_m;
  int  lvl_m[5];
  string tag_m[NP];

  task automatic check(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s time %0t got %0d exp %0d", tag, $time, got, exp);
    end
  endtask

  task automatic hold_step(input int i, input int req);
    if (req != lit_m[i] && age_m[i] == HOLD) begin
      lit_m[i] = req; age_m[i] = 1;
    end else if (age_m[i] != HOLD) age_m[i]++;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      for (int i = 0; i < NL; i++) begin lit_m[i] = 0; age_m[i] = HOLD; end
      blink_m = 0; bcnt_m = 0; colc_m = 0; win_m = 0; busy_m = 0;
      for (int k = 0; k < 5; k++) lvl_m[k] = 0;
      since_rst = 0;
    end else begin
      for (int p = 0; p < NP; p++) begin
        int a, e;
        if (!sig_det[p])       begin a = 0; e = 0; tag_m[p] = "R2"; end
        else if (!link_up[p])  begin a = 0; e = blink_m; tag_m[p] = "R3/R7"; end
        else if (port_excl[p]) begin a = 1; e = 1; tag_m[p] = "R5"; end
        else if (bad_car[p])   begin a = 1 - blink_m; e = blink_m; tag_m[p] = "R6/R7"; end
        else if (rx_pkt[p])    begin a = 1 - blink_m; e = 0; tag_m[p] = "R4/R7"; end
        else                   begin a = 1; e = 0; tag_m[p] = "R4"; end
        hold_step(p, a);
        hold_step(NP + p, e);
      end
      hold_step(2 * NP, (colc_m != 0) ? 1 : 0);
      for (int k = 0; k < 5; k++) hold_step(2 * NP + 1 + k, lvl_m[k]);
      if (col_evt) colc_m = HOLD; else if (colc_m != 0) colc_m--;
      if (win_m == WLEN - 1) begin
        int b;
        b = busy_m + medium_busy;
        lvl_m[0] = (b * 100 > WLEN) ? 1 : 0;
        lvl_m[1] = (b * 1000 > 125 * WLEN) ? 1 : 0;
        lvl_m[2] = (b * 100 > 25 * WLEN) ? 1 : 0;
        lvl_m[3] = (b * 100 > 50 * WLEN) ? 1 : 0;
        lvl_m[4] = (b * 100 > 60 * WLEN) ? 1 : 0;
        busy_m = 0; win_m = 0;
      end else begin
        busy_m += medium_busy; win_m++;
      end
      if (bcnt_m == HOLD - 1) begin bcnt_m = 0; blink_m = 1 - blink_m; end
      else bcnt_m++;
      since_rst++;
    end
    started = 1;
  end

  // per-cycle comparison against the model, plus an independent run-length check (R8)
  int  prev_lv[NL], run_lv[NL];
  bit  moved[NL];
  always @(negedge clk) begin
    if (started && !rst) begin
      int cur[NL];
      for (int p = 0; p < NP; p++) begin
        cur[p] = act_led_n[p]; cur[NP + p] = err_led_n[p];
        check(act_led_n[p], 1 - lit_m[p], {tag_m[p], " act"});
        check(err_led_n[p], 1 - lit_m[NP + p], {tag_m[p], " err"});
      end
      cur[2 * NP] = col_led_n;
      check(col_led_n, 1 - lit_m[2 * NP], "R9 col");
      for (int k = 0; k < 5; k++) begin
        cur[2 * NP + 1 + k] = util_led_n[k];
        check(util_led_n[k], 1 - lit_m[2 * NP + 1 + k], "R10/R11 util");
      end
      for (int i = 0; i < NL; i++) begin
        if (cur[i] != prev_lv[i]) begin
          if (moved[i]) check(run_lv[i] >= HOLD ? 1 : 0, 1, "R8 run length");
          moved[i] = 1; run_lv[i] = 1; prev_lv[i] = cur[i];
        end else run_lv[i]++;
      end
    end else begin
      for (int i = 0; i < NL; i++) begin prev_lv[i] = 1; run_lv[i] = 0; moved[i] = 0; end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic util_window(input int k);
    while (since_rst % WLEN != 0) @(negedge clk);
    for (int i = 0; i < WLEN; i++) begin
      medium_busy = (i < k);
      @(negedge clk);
    end
    medium_busy = 0;
  endtask

  initial begin
    wait_cyc(4);
    // R1: all lamps unlit during and just after reset
    check(act_led_n, 4'hF, "R1 act");
    check(err_led_n, 4'hF, "R1 err");
    check(col_led_n, 1, "R1 col");
    check(util_led_n, 5'h1F, "R1 util");
    rst = 0;
    @(negedge clk);
    check({act_led_n, err_led_n, col_led_n, util_led_n}, 14'h3FFF, "R1 release");
    // R2 R3 R4: no signal, signal without link, link idle, link receiving
    sig_det = 4'b1110; link_up = 4'b1100; rx_pkt = 4'b1000;
    wait_cyc(100);
    // R5 R6 R2: excluded wins over bad carrier and rx; bad carrier; signal lost
    sig_det = 4'b0111; link_up = 4'b0111; port_excl = 4'b0101;
    bad_car = 4'b0011; rx_pkt = 4'b0001;
    wait_cyc(100);
    // R8: fast toggling request on port 2 must not produce short periods
    port_excl = 4'b0001; bad_car = 4'b0000;
    for (int i = 0; i < 60; i++) begin rx_pkt[2] = i[0]; bad_car[1] = i[1]; @(negedge clk); end
    rx_pkt = '0; bad_car = '0;
    // R9: single collision, then a retriggered train
    col_evt = 1; @(negedge clk); col_evt = 0;
    wait_cyc(30);
    for (int i = 0; i < 6; i++) begin col_evt = 1; @(negedge clk); col_evt = 0; wait_cyc(2); end
    wait_cyc(20);
    col_evt = 1; @(negedge clk); col_evt = 0;
    wait_cyc(3);
    // R10 R11: busy counts on either side of each threshold (window 256)
    util_window(0);   util_window(2);   util_window(3);
    util_window(32);  util_window(33);  util_window(64);
    util_window(65);  util_window(128); util_window(129);
    util_window(153); util_window(154); util_window(256);
    util_window(0);
    wait_cyc(2 * HOLD + 2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    errors++;
    $display("FAIL watchdog expired at cycle %0d exp completion", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule